// File: doc/BRIEF.md
# Joinable Dual-Channel Pulse-Width Modulator

The block holds two pulse-width channels. Each channel takes a period, a duty value, a polarity bit, an enable and an alignment-mode bit, and drives its own waveform pin. The counters advance only on cycles where the shared count-enable input is high. The count-enable is the rate control: an external divider pulses it, and the channel logic always runs on the system clock.

Each channel counts in one of two ways. In left-aligned mode the counter runs up and wraps. In center-aligned mode it runs up and then back down, so one output period is twice the period value. New period, duty and mode values are held back until the running period completes. This means a reprogrammed channel never emits a truncated or stretched cycle.

A join control merges the two 8-bit channels into one 16-bit channel. Channel 0 supplies the upper byte of the period and duty, and channel 1 supplies the lower byte. The merged waveform leaves on channel 1's pin, and channel 0's pin rests at its idle level. The join setting is sampled only while both channels are switched off.

Top module: `pwm_pair`

## Requirements
- R1: In left-aligned mode (mode bit 0) the counter steps 0, 1, ..., PER-1 and wraps, so the output period is PER counted cycles.
- R2: In center-aligned mode (mode bit 1) the counter steps up from 0 to PER and back down to 1, so the output period is 2*PER counted cycles.
- R3: With polarity 0 the output is high for a fraction (PER-DTY)/PER of each period, and with polarity 1 for DTY/PER, in both alignment modes.
- R4: With polarity 0, DTY=0 gives a constant high output and DTY>=PER gives a constant low output; polarity 1 gives the opposite levels. PER=0 gives a constant output at the idle level.
- R5: A counter advances only on clock cycles where cnt_en_i is high; halving the count-enable rate doubles the period and keeps the duty fraction.
- R6: A disabled channel clears its counter and drives its idle level, which is the inverse of its polarity bit (polarity 0 idles high, polarity 1 idles low). Both pins are at idle after reset.
- R7: Period, duty and mode inputs are copied into the working registers only when a period completes, or on every cycle while the channel is disabled.
- R8: The join state takes the value of join_i only on cycles where both ena0_i and ena1_i are low; a change while either channel is enabled has no effect.
- R9: While joined, the 16-bit period is {per0_i, per1_i} and the 16-bit duty is {dty0_i, dty1_i}, with channel 0 as the upper byte. Channel 1's enable, polarity and mode govern the merged channel, and its waveform appears on pwm1_o.
- R10: While joined, pwm0_o holds channel 0's idle level, the inverse of pol0_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count-enable strobe shared by all counters |
| join_i | input | 1 | Requested join of the two channels into one 16-bit channel |
| ena0_i | input | 1 | Channel 0 enable |
| per0_i | input | 8 | Channel 0 period (upper byte when joined) |
| dty0_i | input | 8 | Channel 0 duty (upper byte when joined) |
| pol0_i | input | 1 | Channel 0 polarity |
| ctr0_i | input | 1 | Channel 0 alignment mode: 0 left, 1 center |
| ena1_i | input | 1 | Channel 1 enable (merged channel enable when joined) |
| per1_i | input | 8 | Channel 1 period (lower byte when joined) |
| dty1_i | input | 8 | Channel 1 duty (lower byte when joined) |
| pol1_i | input | 1 | Channel 1 polarity (merged channel polarity when joined) |
| ctr1_i | input | 1 | Channel 1 alignment mode (merged channel mode when joined) |
| pwm0_o | output | 1 | Channel 0 waveform |
| pwm1_o | output | 1 | Channel 1 waveform, or merged waveform when joined |

## Verification
Left-aligned and center-aligned counting can give the same duty fraction. For that reason the bench counts rising edges as well as high cycles, so a design that counted only one way would show twice or half the expected edges. It programs a new period in the middle of a running one and expects the old period to finish first. A design that applied the value at once would run its counter past the new limit and lose the waveform for many cycles. The bench sets DTY to 0, DTY to PER or above, and PER to 0, where a comparator off by one would leave a one-cycle spike. It also moves join_i while a channel runs, including while joined, where a design that accepted the change would switch the active output or its byte order.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  typedef enum logic {
    ALIGN_LEFT   = 1'b0,
    ALIGN_CENTER = 1'b1
  } align_e;
endpackage

// File: rtl/pwm_cnt.sv
module pwm_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         step_i,
  input  logic [W-1:0] per_i,
  input  logic [W-1:0] dty_i,
  input  logic         ctr_i,
  output logic [W-1:0] cnt_o,
  output logic         dn_o,
  output logic [W-1:0] per_o,
  output logic [W-1:0] dty_o
);
  import pwm_pair_pkg::*;

  logic [W-1:0] cnt_q, per_q, dty_q;
  logic         dn_q;
  align_e       mode_q;
  logic         per_zero, wrap, load;

  assign per_zero = (per_q == '0);
  assign wrap = (mode_q == ALIGN_CENTER) ? (dn_q && cnt_q == W'(1))
                                         : (cnt_q == per_q - W'(1));
  // shadow update: period boundary, or continuously while idle
  assign load = !en_i || per_zero || (step_i && wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= '0;
      dty_q  <= '0;
      mode_q <= ALIGN_LEFT;
      cnt_q  <= '0;
      dn_q   <= 1'b0;
    end else begin
      if (load) begin
        per_q  <= per_i;
        dty_q  <= dty_i;
        mode_q <= align_e'(ctr_i);
      end
      if (!en_i || per_zero) begin
        cnt_q <= '0;
        dn_q  <= 1'b0;
      end else if (step_i) begin
        if (mode_q == ALIGN_CENTER) begin
          if (dn_q) begin
            cnt_q <= cnt_q - W'(1);
            if (cnt_q == W'(1)) dn_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + W'(1);
            if (cnt_q + W'(1) == per_q) dn_q <= 1'b1;
          end
        end else begin
          cnt_q <= wrap ? '0 : cnt_q + W'(1);
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign dn_o  = dn_q;
  assign per_o = per_q;
  assign dty_o = dty_q;

  a_r1_left_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !per_zero && mode_q == ALIGN_LEFT) |-> (cnt_q < per_q));

  a_r2_center_turn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !per_zero && mode_q == ALIGN_CENTER) |-> (cnt_q <= per_q) && !(cnt_q == per_q && !dn_q));

  a_r5_hold_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !per_zero && !step_i) |=> $stable(cnt_q) && $stable(dn_q));

  a_r7_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !per_zero && !(step_i && wrap)) |=> $stable(per_q) && $stable(dty_q));
endmodule

// File: rtl/pwm_out.sv
module pwm_out #(
  parameter int unsigned W = 8
) (
  input  logic         en_i,
  input  logic         pol_i,
  input  logic [W-1:0] cnt_i,
  input  logic         dn_i,
  input  logic [W-1:0] per_i,
  input  logic [W-1:0] dty_i,
  output logic         out_o
);
  logic above;

  // down phase compares strictly so both edges sit symmetric about the apex
  assign above = dn_i ? (cnt_i > dty_i) : (cnt_i >= dty_i);
  assign out_o = (!en_i || per_i == '0) ? ~pol_i : (above ^ pol_i);
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         step_i,
  input  logic [W-1:0] per_i,
  input  logic [W-1:0] dty_i,
  input  logic         pol_i,
  input  logic         ctr_i,
  output logic         out_o
);
  logic [W-1:0] cnt, per_q, dty_q;
  logic         dn;

  pwm_cnt #(.W(W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .step_i (step_i),
    .per_i  (per_i),
    .dty_i  (dty_i),
    .ctr_i  (ctr_i),
    .cnt_o  (cnt),
    .dn_o   (dn),
    .per_o  (per_q),
    .dty_o  (dty_q)
  );

  pwm_out #(.W(W)) u_out (
    .en_i  (en_i),
    .pol_i (pol_i),
    .cnt_i (cnt),
    .dn_i  (dn),
    .per_i (per_q),
    .dty_i (dty_q),
    .out_o (out_o)
  );
endmodule

// File: rtl/pwm_join.sv
module pwm_join (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ena0_i,
  input  logic ena1_i,
  input  logic join_i,
  output logic join_o
);
  logic join_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                join_q <= 1'b0;
    else if (!ena0_i && !ena1_i) join_q <= join_i;
  end

  assign join_o = join_q;

  a_r8_join_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ena0_i || ena1_i) |=> (join_q == $past(join_q)));
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair #(
  parameter int unsigned CH_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cnt_en_i,
  input  logic            join_i,
  input  logic            ena0_i,
  input  logic [CH_W-1:0] per0_i,
  input  logic [CH_W-1:0] dty0_i,
  input  logic            pol0_i,
  input  logic            ctr0_i,
  input  logic            ena1_i,
  input  logic [CH_W-1:0] per1_i,
  input  logic [CH_W-1:0] dty1_i,
  input  logic            pol1_i,
  input  logic            ctr1_i,
  output logic            pwm0_o,
  output logic            pwm1_o
);
  localparam int unsigned NCH    = 2;
  localparam int unsigned WIDE_W = 2 * CH_W;

  logic            join_q;
  logic            ena_a [NCH];
  logic [CH_W-1:0] per_a [NCH];
  logic [CH_W-1:0] dty_a [NCH];
  logic            pol_a [NCH];
  logic            ctr_a [NCH];
  logic            nar_out [NCH];
  logic            wide_out;

  assign ena_a[0] = ena0_i;  assign ena_a[1] = ena1_i;
  assign per_a[0] = per0_i;  assign per_a[1] = per1_i;
  assign dty_a[0] = dty0_i;  assign dty_a[1] = dty1_i;
  assign pol_a[0] = pol0_i;  assign pol_a[1] = pol1_i;
  assign ctr_a[0] = ctr0_i;  assign ctr_a[1] = ctr1_i;

  pwm_join u_join (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ena0_i (ena0_i),
    .ena1_i (ena1_i),
    .join_i (join_i),
    .join_o (join_q)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_nar
    pwm_chan #(.W(CH_W)) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (ena_a[g] && !join_q),
      .step_i (cnt_en_i),
      .per_i  (per_a[g]),
      .dty_i  (dty_a[g]),
      .pol_i  (pol_a[g]),
      .ctr_i  (ctr_a[g]),
      .out_o  (nar_out[g])
    );
  end

  // merged channel: channel 0 is the upper byte, channel 1 owns the controls
  pwm_chan #(.W(WIDE_W)) u_wide (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ena1_i && join_q),
    .step_i (cnt_en_i),
    .per_i  ({per0_i, per1_i}),
    .dty_i  ({dty0_i, dty1_i}),
    .pol_i  (pol1_i),
    .ctr_i  (ctr1_i),
    .out_o  (wide_out)
  );

  assign pwm0_o = join_q ? ~pol0_i : nar_out[0];
  assign pwm1_o = join_q ? wide_out : nar_out[1];

  a_r6_idle_ch0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ena0_i |-> (pwm0_o == ~pol0_i));

  a_r6_idle_ch1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ena1_i |-> (pwm1_o == ~pol1_i));
endmodule

// File: tb/sim_pwm_pair.sv
`timescale 1ns/1ps
module sim_pwm_pair;
  localparam int unsigned CH_W = 8;

  typedef struct {
    string tag;
    int    win;
    int    h0, r0, h1, r1;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0, cnt_en = 1'b1, half = 1'b0, join_r = 1'b0;
  logic ena0 = 1'b0, pol0 = 1'b0, ctr0 = 1'b0;
  logic ena1 = 1'b0, pol1 = 1'b0, ctr1 = 1'b0;
  logic [CH_W-1:0] per0 = '0, dty0 = '0, per1 = '0, dty1 = '0;
  logic pwm0, pwm1;

  int checks = 0, fails = 0, issued = 0, done = 0;
  item_t q[$];
  item_t cur;
  bit    act = 0;
  int    n, hc0, rc0, hc1, rc1;
  logic  s0, s1, p0 = 1'b1, p1 = 1'b1;

  always #4 clk = ~clk;

  always @(negedge clk) cnt_en <= half ? ~cnt_en : 1'b1;

  pwm_pair #(.CH_W(CH_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en), .join_i(join_r),
    .ena0_i(ena0), .per0_i(per0), .dty0_i(dty0), .pol0_i(pol0), .ctr0_i(ctr0),
    .ena1_i(ena1), .per1_i(per1), .dty1_i(dty1), .pol1_i(pol1), .ctr1_i(ctr1),
    .pwm0_o(pwm0), .pwm1_o(pwm1)
  );

  task automatic judge(string tag, int ch, int h, int r, int eh, int er);
    checks++;
    if (h != eh || r != er) begin
      fails++;
      $display("FAIL %s pwm%0d: high=%0d rises=%0d, expected high=%0d rises=%0d", tag, ch, h, r, eh, er);
    end
  endtask

  // monitor: samples both pins each cycle, scores the item at the queue head
  always @(negedge clk) begin
    #1;
    s0 = pwm0;
    s1 = pwm1;
    if (!act && q.size() > 0) begin
      cur = q.pop_front();
      act = 1;
      n = 0; hc0 = 0; rc0 = 0; hc1 = 0; rc1 = 0;
    end
    if (act) begin
      n++;
      hc0 += int'(s0);
      hc1 += int'(s1);
      if (s0 && !p0) rc0++;
      if (s1 && !p1) rc1++;
      if (n == cur.win) begin
        judge(cur.tag, 0, hc0, rc0, cur.h0, cur.r0);
        judge(cur.tag, 1, hc1, rc1, cur.h1, cur.r1);
        act = 0;
        done++;
      end
    end
    p0 = s0;
    p1 = s1;
  end

  task automatic measure(string tag, int win, int h0, int r0, int h1, int r1);
    item_t it;
    it.tag = tag; it.win = win; it.h0 = h0; it.r0 = r0; it.h1 = h1; it.r1 = r1;
    q.push_back(it);
    issued++;
    wait (done == issued);
  endtask

  task automatic cfg0(int p, int d, logic pl, logic c);
    per0 = CH_W'(p); dty0 = CH_W'(d); pol0 = pl; ctr0 = c;
  endtask

  task automatic cfg1(int p, int d, logic pl, logic c);
    per1 = CH_W'(p); dty1 = CH_W'(d); pol1 = pl; ctr1 = c;
  endtask

  task automatic start(logic e0, logic e1);
    @(negedge clk); ena0 = e0; ena1 = e1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    measure("R6 reset idle", 4, 4, 0, 4, 0);

    // R1 R3: left-aligned, both polarities
    @(negedge clk); ena0 = 0; ena1 = 0; cfg0(10, 3, 0, 0); cfg1(10, 3, 1, 0);
    start(1, 1);
    measure("R1 R3 left", 30, 21, 3, 9, 3);

    // R2: center vs left at equal settings, edges tell them apart
    @(negedge clk); ena0 = 0; ena1 = 0; cfg0(4, 1, 0, 1); cfg1(4, 1, 0, 0);
    start(1, 1);
    measure("R2 R3 center vs left", 16, 12, 2, 12, 4);

    @(negedge clk); ena0 = 0; ena1 = 0; cfg0(5, 3, 1, 1); cfg1(3, 2, 0, 1);
    start(1, 1);
    measure("R2 R3 center pol", 30, 18, 3, 10, 5);

    // R4 constant levels
    @(negedge clk); ena0 = 0; ena1 = 0; cfg0(5, 0, 0, 0); cfg1(5, 7, 1, 1);
    start(1, 1);
    measure("R4 dty0 / dty>per", 10, 10, 0, 10, 0);
    @(negedge clk); ena0 = 0; ena1 = 0; cfg0(5, 5, 0, 0); cfg1(0, 2, 1, 0);
    start(1, 1);
    measure("R4 dty=per / per0", 10, 0, 0, 0, 0);

    // R5 half count rate, ch1 idle at pol 0
    @(negedge clk); ena0 = 0; ena1 = 0; cfg0(4, 1, 0, 0); cfg1(4, 1, 0, 0); half = 1;
    start(1, 0);
    measure("R5 R6 half rate", 16, 12, 2, 16, 0);
    @(negedge clk); ena0 = 0; half = 0;

    // R7 mid-period reprogram: old period completes first
    @(negedge clk); cfg0(8, 4, 0, 0);
    @(negedge clk); ena0 = 1;
    @(negedge clk);
    @(negedge clk); cfg0(2, 1, 0, 0);
    measure("R7 old period kept", 6, 4, 1, 6, 0);
    @(negedge clk);
    measure("R7 new period", 8, 4, 4, 8, 0);

    // R8 join request while ch0 runs is ignored
    @(negedge clk); ena0 = 0; cfg0(4, 2, 0, 0);
    start(1, 0);
    join_r = 1;
    @(negedge clk);
    measure("R8 join ignored", 8, 4, 2, 8, 0);

    // R9 R10 joined, left-aligned: PER=0x0100, DTY=0x0040, pol 1
    @(negedge clk); ena0 = 0; ena1 = 0; cfg0(8'h01, 8'h00, 0, 0); cfg1(8'h00, 8'h40, 1, 0);
    start(0, 1);
    measure("R9 R10 joined left", 512, 512, 0, 128, 2);

    // joined center-aligned, ch0 idle now low: PER=0x0100, DTY=0x0080
    @(negedge clk); ena1 = 0; cfg0(8'h01, 8'h00, 1, 0); cfg1(8'h00, 8'h80, 0, 1);
    start(0, 1);
    measure("R9 R10 joined center", 512, 0, 0, 256, 1);
    join_r = 0;
    @(negedge clk);
    measure("R8 unjoin ignored", 512, 0, 0, 256, 1);

    // R8 join released once both are off
    @(negedge clk); ena1 = 0; cfg0(4, 0, 0, 0); cfg1(4, 1, 1, 0);
    @(negedge clk);
    start(0, 1);
    measure("R8 R9 unjoined after idle", 8, 8, 0, 2, 2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule